// File: doc/BRIEF.md
# GPIO Interrupt Sense Unit

This block watches a bank of general-purpose input pins and turns selected activity on them into interrupt requests. Each pin gets its own sense mode: rising edge, falling edge, either edge, high level or low level. A detected event sets a pending latch for the pin. Software clears that latch with a write-one-to-clear acknowledge. Two separate per-pin controls decide what happens. A detection-enable bit decides whether a pin can become pending at all. An independent interrupt mask, changed through dedicated set and clear registers, decides whether a pending pin reaches a request output.

Pins are brought into the clock domain through a two-stage synchroniser, and edges are found between consecutive synchronised samples. Raw and masked pending status can be read back. Two request lines are driven: one covers the lower half of the pins and one covers the upper half. A handler reads the masked status, services the lowest set bit, acknowledges it, and repeats until the status reads zero. To change a pin's sense mode, software first clears its detection-enable bit, then writes the new mode, then sets the bit again.

The register bus is a plain single-cycle interface. A write takes effect on the clock edge where `bus_we` is high. Read data is a combinational function of `bus_addr`. The bus has no back-pressure: every access completes in one cycle.

Top module: `gpio_irq_sense`

## Requirements
- R1: After reset, every pending bit, detection-enable bit, unmask bit and sense field is 0, and both request outputs are low.
- R2: Pin n's 4-bit sense field sits in the sense register at byte offset 0x40 + 4*(n/8), at bits 4*(n mod 8)+3 down to 4*(n mod 8). Sense registers read back exactly what was written.
- R3: Sense code 0x8 sets the pin's pending bit on a synchronised 0-to-1 transition only.
- R4: Sense code 0x9 sets the pending bit on a synchronised 1-to-0 transition only.
- R5: Sense code 0xC sets the pending bit on either transition.
- R6: Sense code 0xA (high) and sense code 0xB (low) set the pending bit on every cycle the synchronised level is active. While that level lasts, an acknowledge has no lasting effect.
- R7: Any other sense code never sets the pending bit.
- R8: The detection-enable register at offset 0x14 is read/write. A pin whose enable bit is 0 never becomes pending.
- R9: Writing 1 to a bit at offset 0x28 clears that pin's pending bit, unless a new event sets it in the same cycle. Bits written as 0 have no effect.
- R10: Writing 1 to a bit at offset 0x18 unmasks that pin, and writing 1 to a bit at offset 0x1C masks it. Bits written as 0 leave the mask unchanged. Reading offset 0x18 or 0x1C returns the unmask vector, where 1 means unmasked.
- R11: Offset 0x20 reads the raw pending bits. Offset 0x24 reads the pending bits ANDed with the unmask vector.
- R12: `irq_lo` is the OR of masked pending bits 0 to 15, and `irq_hi` is the OR of masked pending bits 16 to 31.
- R13: A pin value sampled at clock edge t can set its pending bit at edge t+2 at the earliest. That pending bit is visible at the ports after edge t+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pin_i | input | 32 | Asynchronous GPIO input levels |
| irq_lo | output | 1 | Request for pins 0 to 15 |
| irq_hi | output | 1 | Request for pins 16 to 31 |

## Verification
The assertions assume the following about the inputs:
- Reset is held low across at least one clock edge.
- Every bus write lasts exactly one cycle, at a word-aligned address.
- Pin changes are meant to be seen as levels held for several cycles.

The stimulus keeps within these assumptions. It changes pins and bus signals just after a rising edge and holds each pin pattern for at least four cycles. It parks the address on the raw status register whenever the bus is idle, so that status can be compared against the behavioural model on every clock.

// File: rtl/gis_pkg.sv
package gis_pkg;
  localparam int DW     = 32;
  localparam int AW     = 8;

  localparam logic [3:0] SNS_RISE = 4'h8;
  localparam logic [3:0] SNS_FALL = 4'h9;
  localparam logic [3:0] SNS_HIGH = 4'hA;
  localparam logic [3:0] SNS_LOW  = 4'hB;
  localparam logic [3:0] SNS_BOTH = 4'hC;

  localparam logic [AW-1:0] OFS_DETEN  = 8'h14;
  localparam logic [AW-1:0] OFS_UNMSET = 8'h18;
  localparam logic [AW-1:0] OFS_MSKSET = 8'h1C;
  localparam logic [AW-1:0] OFS_RAW    = 8'h20;
  localparam logic [AW-1:0] OFS_MASKED = 8'h24;
  localparam logic [AW-1:0] OFS_ACK    = 8'h28;
  localparam logic [AW-1:0] OFS_SNS0   = 8'h40;
endpackage

// File: rtl/gis_sync.sv
module gis_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] cur_o,
  output logic [W-1:0] prev_o
);
  logic [W-1:0] meta_q, cur_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      cur_q  <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= async_i;
      cur_q  <= meta_q;
      prev_q <= cur_q;
    end
  end

  assign cur_o  = cur_q;
  assign prev_o = prev_q;

  AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> prev_q == $past(cur_q)); // R13
endmodule

// File: rtl/gis_detect.sv
module gis_detect
  import gis_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [4*NPIN-1:0] sense_i,
  input  logic [NPIN-1:0]   en_i,
  input  logic [NPIN-1:0]   cur_i,
  input  logic [NPIN-1:0]   prev_i,
  input  logic [NPIN-1:0]   ack_i,
  output logic [NPIN-1:0]   pend_o
);
  logic [NPIN-1:0] hit, pend_q;

  for (genvar i = 0; i < NPIN; i++) begin : g_pin
    logic [3:0] mode;
    assign mode = sense_i[4*i +: 4];

    always_comb begin
      unique case (mode)
        SNS_RISE: hit[i] =  cur_i[i] & ~prev_i[i];
        SNS_FALL: hit[i] = ~cur_i[i] &  prev_i[i];
        SNS_BOTH: hit[i] =  cur_i[i] ^  prev_i[i];
        SNS_HIGH: hit[i] =  cur_i[i];
        SNS_LOW:  hit[i] = ~cur_i[i];
        default:  hit[i] = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pend_q[i] <= 1'b0;
      else        pend_q[i] <= (pend_q[i] & ~ack_i[i]) | (en_i[i] & hit[i]);
    end

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_i[i] && !pend_q[i]) |=> !pend_q[i]); // R8
    AST_LEVEL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i[i] && ((mode == SNS_HIGH && cur_i[i]) || (mode == SNS_LOW && !cur_i[i])))
      |=> pend_q[i]); // R6
    AST_BAD_CODE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[3] == 1'b0 && !pend_q[i]) |=> !pend_q[i]); // R7
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[i] && !en_i[i]) |=> !pend_q[i]); // R9
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/gis_regs.sv
module gis_regs
  import gis_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic [NPIN-1:0]   pend_i,
  output logic [DW-1:0]     rdata_o,
  output logic [NPIN-1:0]   en_o,
  output logic [NPIN-1:0]   unmask_o,
  output logic [4*NPIN-1:0] sense_o,
  output logic [NPIN-1:0]   ack_o
);
  localparam int NSR = NPIN / 8;

  logic [NPIN-1:0] en_q, unm_q;
  logic [DW-1:0]   sns_q [NSR];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      unm_q <= '0;
    end else if (we_i) begin
      if (addr_i == OFS_DETEN)  en_q  <= wdata_i[NPIN-1:0];
      if (addr_i == OFS_UNMSET) unm_q <= unm_q | wdata_i[NPIN-1:0];
      if (addr_i == OFS_MSKSET) unm_q <= unm_q & ~wdata_i[NPIN-1:0];
    end
  end

  for (genvar k = 0; k < NSR; k++) begin : g_sns
    localparam logic [AW-1:0] SNS_ADDR = OFS_SNS0 + AW'(4*k);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            sns_q[k] <= '0;
      else if (we_i && addr_i == SNS_ADDR)   sns_q[k] <= wdata_i;
    end
    assign sense_o[32*k +: 32] = sns_q[k];
  end

  assign ack_o    = (we_i && addr_i == OFS_ACK) ? wdata_i[NPIN-1:0] : '0;
  assign en_o     = en_q;
  assign unmask_o = unm_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_DETEN)                              rdata_o = DW'(en_q);
    if (addr_i == OFS_UNMSET || addr_i == OFS_MSKSET)     rdata_o = DW'(unm_q);
    if (addr_i == OFS_RAW)                                rdata_o = DW'(pend_i);
    if (addr_i == OFS_MASKED)                             rdata_o = DW'(pend_i & unm_q);
    for (int k = 0; k < NSR; k++)
      if (addr_i == OFS_SNS0 + AW'(4*k))                  rdata_o = sns_q[k];
  end

  AST_UNMASK_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == OFS_UNMSET) |=> ((unm_q & $past(unm_q)) == $past(unm_q))); // R10
  AST_MASK_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i == OFS_MSKSET) |=> ((unm_q | $past(unm_q)) == $past(unm_q))); // R10
endmodule

// File: rtl/gpio_irq_sense.sv
module gpio_irq_sense
  import gis_pkg::*;
#(
  parameter int NPIN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_we,
  input  logic [7:0]      bus_addr,
  input  logic [31:0]     bus_wdata,
  output logic [31:0]     bus_rdata,
  input  logic [NPIN-1:0] pin_i,
  output logic            irq_lo,
  output logic            irq_hi
);
  localparam int HALF = NPIN / 2;

  logic [NPIN-1:0]   cur, prev, en, unmask, ack, pend, active;
  logic [4*NPIN-1:0] sense;

  gis_sync #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pin_i), .cur_o(cur), .prev_o(prev)
  );

  gis_regs #(.NPIN(NPIN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(bus_we), .addr_i(bus_addr),
    .wdata_i(bus_wdata), .pend_i(pend), .rdata_o(bus_rdata),
    .en_o(en), .unmask_o(unmask), .sense_o(sense), .ack_o(ack)
  );

  gis_detect #(.NPIN(NPIN)) u_det (
    .clk(clk), .rst_n(rst_n), .sense_i(sense), .en_i(en),
    .cur_i(cur), .prev_i(prev), .ack_i(ack), .pend_o(pend)
  );

  assign active = pend & unmask;
  assign irq_lo = |active[HALF-1:0];
  assign irq_hi = |active[NPIN-1:HALF];

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (unmask == '0) |-> (!irq_lo && !irq_hi)); // R10
  AST_LO_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[HALF-1:0] == '0) |-> !irq_lo); // R12
  AST_HI_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend[NPIN-1:HALF] == '0) |-> !irq_hi); // R12
endmodule

// File: tb/tb_gpio_irq_sense.sv
`timescale 1ns/1ps
module tb_gpio_irq_sense;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h20;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_i = '0;
  logic        irq_lo, irq_hi;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_irq_sense dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // behavioural reference model
  logic [31:0] m_en, m_un, m_pend;
  logic [31:0] m_sr [4];
  logic [31:0] hist [$];

  function automatic bit m_hit(int i, logic [31:0] c, logic [31:0] p);
    logic [3:0] code;
    code = m_sr[i / 8][4 * (i % 8) +: 4];
    case (code)
      4'h8: return c[i] && !p[i];
      4'h9: return !c[i] && p[i];
      4'hC: return c[i] != p[i];
      4'hA: return c[i];
      4'hB: return !c[i];
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = 0; m_un = 0; m_pend = 0;
      foreach (m_sr[k]) m_sr[k] = 0;
      hist = '{32'h0, 32'h0, 32'h0};
    end else begin
      logic [31:0] c, p, nxt, ackv;
      c = hist[1]; p = hist[2];
      ackv = (bus_we && bus_addr == 8'h28) ? bus_wdata : 32'h0;
      for (int i = 0; i < 32; i++)
        nxt[i] = (m_pend[i] && !ackv[i]) || (m_en[i] && m_hit(i, c, p));
      m_pend = nxt;
      if (bus_we) begin
        if (bus_addr == 8'h14) m_en = bus_wdata;
        if (bus_addr == 8'h18) m_un = m_un | bus_wdata;
        if (bus_addr == 8'h1C) m_un = m_un & ~bus_wdata;
        for (int k = 0; k < 4; k++)
          if (bus_addr == 8'h40 + 8'(4 * k)) m_sr[k] = bus_wdata;
      end
      hist.push_front(pin_i);
      void'(hist.pop_back());
    end
  end

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R12 irq_lo", 32'(irq_lo), 32'(|(m_pend[15:0] & m_un[15:0])));
      chk("R12 irq_hi", 32'(irq_hi), 32'(|(m_pend[31:16] & m_un[31:16])));
      if (!bus_we && bus_addr == 8'h20) chk("R13 raw per cycle", bus_rdata, m_pend);
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(posedge clk); #1;
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_we = 1'b0; bus_addr = 8'h20; bus_wdata = '0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(posedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    @(posedge clk); #1;
    bus_addr = 8'h20;
  endtask

  task automatic pins(logic [31:0] v, int hold);
    @(posedge clk); #1;
    pin_i = v;
    repeat (hold) @(posedge clk);
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq", {30'h0, irq_hi, irq_lo}, 32'h0);
    rd(8'h14, d); chk("R1 enable", d, 32'h0);
    rd(8'h18, d); chk("R1 unmask", d, 32'h0);
    rd(8'h20, d); chk("R1 pending", d, 32'h0);
    rd(8'h40, d); chk("R1 sense", d, 32'h0);

    // R2: field placement, pin 9 uses bits 7:4 of 0x44
    wr(8'h44, 32'h1234_56A7);
    rd(8'h44, d); chk("R2 readback", d, 32'h1234_56A7);
    chk("R2 pin9 field", 32'(d[7:4]), 32'hA);
    wr(8'h44, 32'h0);

    // pins 0..7: rise,fall,both,high,low,bad(3),rise,rise ; pin16 rise
    wr(8'h40, 32'h883B_AC98);
    wr(8'h48, 32'h0000_0008);
    wr(8'h14, 32'h0001_00BF);   // pin 6 disabled
    rd(8'h14, d); chk("R8 enable readback", d, 32'h0001_00BF);
    repeat (4) @(posedge clk);
    rd(8'h20, d); chk("R6 low level pends", d, 32'h0000_0010);

    pins(32'h0000_007F, 5);
    rd(8'h20, d); chk("R3/R5/R7/R8 after rise", d, 32'h0000_001D);
    chk("R4 rise ignored on fall pin", 32'(d[1]), 32'h0);
    chk("R7 bad code pin5", 32'(d[5]), 32'h0);
    chk("R8 disabled pin6", 32'(d[6]), 32'h0);

    wr(8'h28, 32'h0000_001F);
    repeat (2) @(posedge clk);
    rd(8'h20, d); chk("R6/R9 ack vs held level", d, 32'h0000_0008);

    pins(32'h0, 5);
    rd(8'h20, d); chk("R4/R5 after fall", d, 32'h0000_001E);

    wr(8'h28, 32'hFFFF_FFFF);
    repeat (2) @(posedge clk);
    rd(8'h20, d); chk("R6 low still active", d, 32'h0000_0010);
    wr(8'h28, 32'h0);
    rd(8'h20, d); chk("R9 zero ack bits", d, 32'h0000_0010);

    // masking
    wr(8'h18, 32'h0000_0010);
    rd(8'h18, d); chk("R10 unmask readback", d, 32'h0000_0010);
    rd(8'h24, d); chk("R11 masked status", d, 32'h0000_0010);
    @(negedge clk); chk("R12 irq_lo up", 32'(irq_lo), 32'h1);
    wr(8'h1C, 32'h0);
    rd(8'h1C, d); chk("R10 zero mask bits", d, 32'h0000_0010);
    wr(8'h1C, 32'h0000_0010);
    rd(8'h24, d); chk("R11 masked after mask", d, 32'h0);
    @(negedge clk); chk("R10 irq_lo masked", 32'(irq_lo), 32'h0);

    // upper half request
    wr(8'h18, 32'h0001_0000);
    pins(32'h0001_0000, 5);
    @(negedge clk);
    chk("R12 irq_hi", 32'(irq_hi), 32'h1);
    chk("R12 irq_lo stays low", 32'(irq_lo), 32'h0);
    wr(8'h28, 32'h0001_0000);
    @(negedge clk); chk("R9 ack pin16", 32'(irq_hi), 32'h0);

    // R13 latency on pin16
    pins(32'h0, 4);
    @(posedge clk); #1 pin_i = 32'h0001_0000;   // sampled at edge t
    @(posedge clk); #1;                          // after edge t
    chk("R13 not yet at t", 32'(bus_rdata[16]), 32'h0);
    @(posedge clk); #1;                          // after edge t+1
    chk("R13 not yet at t+1", 32'(bus_rdata[16]), 32'h0);
    @(posedge clk); #1;                          // after edge t+2
    chk("R13 pending at t+2", 32'(bus_rdata[16]), 32'h1);

    // disable pin16 and pulse again
    wr(8'h28, 32'h0001_0000);
    wr(8'h14, 32'h0000_00BF);
    pins(32'h0, 4);
    pins(32'h0001_0000, 5);
    rd(8'h20, d); chk("R8 disabled pin16", 32'(d[16]), 32'h0);

    repeat (3) @(posedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule